// File: doc/BRIEF.md
# Serial Presence-Detect Utility Command and Write-Protect Decoder

This block sits behind the bit engine of an I2C slave and interprets the header byte of each bus transfer. The bit engine reports START, STOP, every received byte and a master NoACK as single-cycle events. The block answers every byte it is responsible for with one ACK/NoACK decision. A header whose upper nibble is 1010b, and whose device-select field matches the board straps, is handed to the memory path. A header whose upper nibble is 0110b selects one of the utility commands, which this block executes itself.

The block keeps four write-protect flags, one for each quarter of the memory, and a one-bit active-bank register. Query commands give their answer through the ACK/NoACK response and return no data. Set-protect and clear-all commands must be accompanied by a high-voltage qualifier on the first address strap, which is modelled here as a plain input bit. State changes take effect only on the STOP that closes a fully accepted command. Only the protect-flag updates raise a pulse that requests a non-volatile write cycle.

Top module: `spd_util_decoder`

## Requirements
- R1: After reset all four protect flags are 0, the active bank is 0, and no acknowledge, memory-grant or write-start pulse is produced.
- R2: A header of the form 1010 d2 d1 d0 rw, with d2..d0 equal to the strap input, is acknowledged and raises the memory grant, with the read flag equal to bit 0. If d2..d0 differ from the straps, the header is answered NoACK and no grant is raised.
- R3: A header whose upper nibble is neither 1010b nor 0110b is answered NoACK. So are the unassigned utility codes 0x64, 0x65, 0x67 and 0x6F.
- R4: While the busy input is high, every header is answered NoACK and no memory grant is raised.
- R5: Query codes 0x63, 0x69, 0x6B and 0x61 address blocks 0 to 3. Each is answered ACK when that block's flag is clear and NoACK when it is set.
- R6: Bank query 0x6D is answered ACK while bank 0 is active and NoACK while bank 1 is active.
- R7: Set-protect codes 0x62, 0x68, 0x6A and 0x60 address blocks 0 to 3. With the qualifier high, the header and both dummy bytes are acknowledged. On the following STOP the block's flag becomes 1 and a one-cycle write-start pulse is raised.
- R8: A set-protect header for a block whose flag is already set is answered NoACK. It changes no state and raises no write-start.
- R9: Clear-all code 0x66, with the qualifier high, clears all four flags at STOP and always raises write-start, even when no flag was set.
- R10: If the qualifier is low while any of the three bytes of a set-protect or clear-all command is received, the first two bytes are acknowledged and the third is answered NoACK. Neither flags nor write-start change at the following STOP.
- R11: Bank-select codes 0x6C (bank 0) and 0x6E (bank 1) acknowledge all three bytes regardless of the qualifier. They update the active bank at STOP and never raise write-start.
- R12: An accepted command that is followed by a repeated START instead of a STOP is discarded and changes no state.
- R13: A byte that arrives before any START produces no acknowledge pulse. A byte that arrives after a utility command has completed is answered NoACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_strap | input | 3 | Device-select straps |
| hv_qual | input | 1 | High-voltage qualifier on address strap 0 |
| nv_busy | input | 1 | Non-volatile write cycle in progress |
| ev_start | input | 1 | START or repeated START seen (one cycle) |
| ev_stop | input | 1 | STOP seen (one cycle) |
| ev_byte | input | 1 | A received byte is on rx_data (one cycle) |
| rx_data | input | 8 | Received byte |
| ev_mnack | input | 1 | Master answered NoACK (one cycle) |
| ack_vld | output | 1 | Response decision valid (one cycle after ev_byte) |
| ack_ok | output | 1 | 1 = ACK, 0 = NoACK |
| mem_go | output | 1 | Header granted to the memory path |
| mem_rd | output | 1 | Memory transfer direction, 1 = read |
| prot_flags | output | 4 | Write-protect flag per block |
| bank_act | output | 1 | Active bank |
| nv_wr_start | output | 1 | Request for a non-volatile write cycle |

## Verification
A table of header bytes covers memory headers with matching and non-matching straps, foreign class nibbles, unassigned utility codes, queries on a clean state, and busy headers. This separates class decoding, strap comparison and the busy override. Directed sequences then build up state: a set followed by queries checks which block a code addresses. A second set on the same block checks refusal, and a dropped qualifier on a later byte checks that the qualifier is sampled on every byte rather than only the header. A repeated START before STOP shows that changes wait for the commit. Bank select, bank query and two clear-all commands (one on already clear flags) separate the commands that request a write cycle from those that do not.

// File: rtl/spd_util_pkg.sv
package spd_util_pkg;

  localparam int NUM_BLK = 4;
  localparam int DEV_W   = 3;
  localparam int ARG_W   = $clog2(NUM_BLK);

  typedef enum logic [1:0] {CLS_NONE, CLS_MEM, CLS_UTIL} cls_e;

  typedef enum logic [2:0] {
    OP_BAD, OP_SETP, OP_CLRALL, OP_QRYP, OP_SELB, OP_QRYB
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_ARG1, ST_ARG2, ST_ARMED, ST_MEM, ST_DONE
  } st_e;

  typedef struct packed {
    cls_e             cls;
    op_e              op;
    logic [ARG_W-1:0] arg;
    logic             rd;
    logic [DEV_W-1:0] dev;
  } hdr_t;

  // Header byte -> class, operation and operand (block index or bank).
  function automatic hdr_t decode_hdr(input logic [7:0] b);
    hdr_t h;
    h.cls = CLS_NONE;
    h.op  = OP_BAD;
    h.arg = '0;
    h.rd  = b[0];
    h.dev = b[3:1];
    if (b[7:4] == 4'hA) begin
      h.cls = CLS_MEM;
    end else if (b[7:4] == 4'h6) begin
      h.cls = CLS_UTIL;
      case (b[3:0])
        4'h2: begin h.op = OP_SETP; h.arg = 2'd0; end
        4'h8: begin h.op = OP_SETP; h.arg = 2'd1; end
        4'hA: begin h.op = OP_SETP; h.arg = 2'd2; end
        4'h0: begin h.op = OP_SETP; h.arg = 2'd3; end
        4'h3: begin h.op = OP_QRYP; h.arg = 2'd0; end
        4'h9: begin h.op = OP_QRYP; h.arg = 2'd1; end
        4'hB: begin h.op = OP_QRYP; h.arg = 2'd2; end
        4'h1: begin h.op = OP_QRYP; h.arg = 2'd3; end
        4'h6: h.op = OP_CLRALL;
        4'hC: begin h.op = OP_SELB; h.arg = 2'd0; end
        4'hE: begin h.op = OP_SELB; h.arg = 2'd1; end
        4'hD: h.op = OP_QRYB;
        default: h.op = OP_BAD;
      endcase
    end
    return h;
  endfunction

endpackage

// File: rtl/spd_hdr_decode.sv
module spd_hdr_decode
  import spd_util_pkg::*;
(
  input  logic [7:0] byte_in,
  output hdr_t       hdr_out
);
  always_comb hdr_out = decode_hdr(byte_in);
endmodule

// File: rtl/spd_prot_store.sv
module spd_prot_store
  import spd_util_pkg::*;
#(
  parameter int N_BLK = NUM_BLK,
  localparam int BW   = $clog2(N_BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  op_e              c_op,
  input  logic [BW-1:0]    c_arg,
  output logic [N_BLK-1:0] flags,
  output logic             bank,
  output logic             wr_start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      bank     <= 1'b0;
      wr_start <= 1'b0;
    end else begin
      wr_start <= 1'b0;
      if (commit) begin
        case (c_op)
          OP_SETP: begin
            flags[c_arg] <= 1'b1;
            wr_start     <= 1'b1;
          end
          OP_CLRALL: begin
            flags    <= '0;
            wr_start <= 1'b1;
          end
          OP_SELB: bank <= c_arg[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spd_xfer_seq.sv
module spd_xfer_seq
  import spd_util_pkg::*;
#(
  parameter int N_BLK = NUM_BLK,
  parameter int DW    = DEV_W,
  localparam int BW   = $clog2(N_BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    dev_strap,
  input  logic             hv_qual,
  input  logic             nv_busy,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_byte,
  input  logic             ev_mnack,
  input  hdr_t             hdr,
  input  logic [N_BLK-1:0] flags,
  input  logic             bank,
  output logic             ack_vld,
  output logic             ack_ok,
  output logic             mem_go,
  output logic             mem_rd,
  output logic             commit,
  output op_e              c_op,
  output logic [BW-1:0]    c_arg,
  output logic             hdr_phase
);
  st_e  st;
  logic hv_ok;

  wire hv_cmd    = (c_op == OP_SETP) || (c_op == OP_CLRALL);
  wire dev_hit   = (hdr.dev == dev_strap);
  wire blk_set   = flags[hdr.arg];

  assign commit    = ev_stop && !ev_start && (st == ST_ARMED);
  assign hdr_phase = (st == ST_HDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      hv_ok   <= 1'b0;
      c_op    <= OP_BAD;
      c_arg   <= '0;
      ack_vld <= 1'b0;
      ack_ok  <= 1'b0;
      mem_go  <= 1'b0;
      mem_rd  <= 1'b0;
    end else begin
      ack_vld <= 1'b0;
      ack_ok  <= 1'b0;
      mem_go  <= 1'b0;
      if (ev_start) begin
        st <= ST_HDR;
      end else if (ev_stop) begin
        st <= ST_IDLE;
      end else if (ev_byte) begin
        case (st)
          ST_HDR: begin
            ack_vld <= 1'b1;
            c_op    <= hdr.op;
            c_arg   <= hdr.arg;
            hv_ok   <= hv_qual;
            st      <= ST_DONE;
            if (nv_busy) begin
              ack_ok <= 1'b0;
            end else if (hdr.cls == CLS_MEM) begin
              if (dev_hit) begin
                ack_ok <= 1'b1;
                mem_go <= 1'b1;
                mem_rd <= hdr.rd;
                st     <= ST_MEM;
              end
            end else if (hdr.cls == CLS_UTIL) begin
              case (hdr.op)
                OP_SETP: begin
                  ack_ok <= !blk_set;
                  if (!blk_set) st <= ST_ARG1;
                end
                OP_CLRALL, OP_SELB: begin
                  ack_ok <= 1'b1;
                  st     <= ST_ARG1;
                end
                OP_QRYP: ack_ok <= !blk_set;
                OP_QRYB: ack_ok <= !bank;
                default: ack_ok <= 1'b0;
              endcase
            end
          end
          ST_ARG1: begin
            ack_vld <= 1'b1;
            ack_ok  <= 1'b1;
            hv_ok   <= hv_ok && hv_qual;
            st      <= ST_ARG2;
          end
          ST_ARG2: begin
            ack_vld <= 1'b1;
            if (hv_cmd) begin
              ack_ok <= hv_ok && hv_qual;
              st     <= (hv_ok && hv_qual) ? ST_ARMED : ST_DONE;
            end else begin
              ack_ok <= 1'b1;
              st     <= ST_ARMED;
            end
          end
          ST_ARMED, ST_DONE: begin
            ack_vld <= 1'b1;
            ack_ok  <= 1'b0;
            st      <= ST_DONE;
          end
          default: ;
        endcase
      end else if (ev_mnack && st != ST_IDLE && st != ST_MEM) begin
        st <= ST_DONE;
      end
    end
  end
endmodule

// File: rtl/spd_util_decoder.sv
module spd_util_decoder
  import spd_util_pkg::*;
#(
  parameter int N_BLK = NUM_BLK,
  parameter int DW    = DEV_W,
  localparam int BW   = $clog2(N_BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    dev_strap,
  input  logic             hv_qual,
  input  logic             nv_busy,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_byte,
  input  logic [7:0]       rx_data,
  input  logic             ev_mnack,
  output logic             ack_vld,
  output logic             ack_ok,
  output logic             mem_go,
  output logic             mem_rd,
  output logic [N_BLK-1:0] prot_flags,
  output logic             bank_act,
  output logic             nv_wr_start
);
  hdr_t          hdr;
  logic          commit;
  op_e           c_op;
  logic [BW-1:0] c_arg;
  logic          hdr_phase;

  spd_hdr_decode u_dec (
    .byte_in (rx_data),
    .hdr_out (hdr)
  );

  spd_xfer_seq #(.N_BLK(N_BLK), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_strap (dev_strap),
    .hv_qual   (hv_qual),
    .nv_busy   (nv_busy),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_byte   (ev_byte),
    .ev_mnack  (ev_mnack),
    .hdr       (hdr),
    .flags     (prot_flags),
    .bank      (bank_act),
    .ack_vld   (ack_vld),
    .ack_ok    (ack_ok),
    .mem_go    (mem_go),
    .mem_rd    (mem_rd),
    .commit    (commit),
    .c_op      (c_op),
    .c_arg     (c_arg),
    .hdr_phase (hdr_phase)
  );

  spd_prot_store #(.N_BLK(N_BLK)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .c_op     (c_op),
    .c_arg    (c_arg),
    .flags    (prot_flags),
    .bank     (bank_act),
    .wr_start (nv_wr_start)
  );
endmodule

// File: rtl/spd_util_sva.sv
module spd_util_sva #(
  parameter int N_BLK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_byte,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             nv_busy,
  input logic             hdr_phase,
  input logic             ack_vld,
  input logic             ack_ok,
  input logic             mem_go,
  input logic [N_BLK-1:0] prot_flags,
  input logic             bank_act,
  input logic             nv_wr_start
);
  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(ev_byte)); // R13

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && hdr_phase && nv_busy && !ev_start && !ev_stop) |=> (ack_vld && !ack_ok && !mem_go)); // R4

  AST_GRANT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |-> (ack_vld && ack_ok)); // R2

  AST_FLAGS_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_flags) |-> $past(ev_stop)); // R12

  AST_BANK_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_act) |-> ($past(ev_stop) && !nv_wr_start)); // R11

  AST_WR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_start |-> ($past(ev_stop) && ((prot_flags == '0) ||
      ($countones(prot_flags) == $countones($past(prot_flags)) + 1)))); // R7
endmodule

bind spd_util_decoder spd_util_sva #(.N_BLK(N_BLK)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_byte     (ev_byte),
  .ev_start    (ev_start),
  .ev_stop     (ev_stop),
  .nv_busy     (nv_busy),
  .hdr_phase   (hdr_phase),
  .ack_vld     (ack_vld),
  .ack_ok      (ack_ok),
  .mem_go      (mem_go),
  .prot_flags  (prot_flags),
  .bank_act    (bank_act),
  .nv_wr_start (nv_wr_start)
);

// File: tb/spd_util_decoder_tb_top.sv
module spd_util_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] dev_strap = 3'b101;
  logic       hv_qual = 1'b0, nv_busy = 1'b0;
  logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0, ev_mnack = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       ack_vld, ack_ok, mem_go, mem_rd, bank_act, nv_wr_start;
  logic [3:0] prot_flags;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  spd_util_decoder dut_i (.*);

  // {busy, header, exp_ack, exp_grant, exp_rd}
  localparam logic [11:0] VEC [12] = '{
    {1'b0, 8'hAB, 1'b1, 1'b1, 1'b1},  // R2 read, straps match
    {1'b0, 8'hAA, 1'b1, 1'b1, 1'b0},  // R2 write
    {1'b0, 8'hA3, 1'b0, 1'b0, 1'b0},  // R2 strap mismatch
    {1'b0, 8'h55, 1'b0, 1'b0, 1'b0},  // R3
    {1'b0, 8'h64, 1'b0, 1'b0, 1'b0},  // R3
    {1'b0, 8'h6F, 1'b0, 1'b0, 1'b0},  // R3
    {1'b0, 8'h63, 1'b1, 1'b0, 1'b0},  // R5 clear flag
    {1'b0, 8'h61, 1'b1, 1'b0, 1'b0},  // R5
    {1'b0, 8'h6D, 1'b1, 1'b0, 1'b0},  // R6 bank 0
    {1'b1, 8'hAB, 1'b0, 1'b0, 1'b0},  // R4
    {1'b1, 8'h63, 1'b0, 1'b0, 1'b0},  // R4
    {1'b0, 8'hE0, 1'b0, 1'b0, 1'b0}   // R3
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
  endtask

  task automatic do_stop(output logic wr);
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
    wr = nv_wr_start;
  endtask

  task automatic send(input logic [7:0] b, output logic vld, output logic ok,
                      output logic mg, output logic mr);
    @(negedge clk); ev_byte = 1'b1; rx_data = b;
    @(negedge clk); ev_byte = 1'b0;
    vld = ack_vld; ok = ack_ok; mg = mem_go; mr = mem_rd;
  endtask

  // Full three-byte command; returns ack pattern and the write pulse at STOP.
  task automatic cmd3(input logic [7:0] b, input logic [2:0] hv,
                      output logic [2:0] acks, output logic wr);
    logic v, o, g, r;
    do_start();
    for (int i = 0; i < 3; i++) begin
      hv_qual = hv[i];
      send((i == 0) ? b : 8'h00, v, o, g, r);
      acks[i] = v & o;
    end
    do_stop(wr);
    hv_qual = 1'b0;
  endtask

  task automatic query(input logic [7:0] b, output logic ok);
    logic v, g, r, wr;
    do_start();
    send(b, v, ok, g, r);
    do_stop(wr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic v, o, g, r, wr;
    logic [2:0] a;
    repeat (3) @(negedge clk);
    chk("R1 flags", {4'h0, prot_flags}, 8'h00);
    chk("R1 bank", {7'h0, bank_act}, 8'h00);
    chk("R1 pulses", {5'h0, ack_vld, mem_go, nv_wr_start}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: byte before any START
    send(8'hAB, v, o, g, r);
    chk("R13 no ack when idle", {6'h0, v, g}, 8'h00);

    foreach (VEC[i]) begin
      nv_busy = VEC[i][11];
      do_start();
      send(VEC[i][10:3], v, o, g, r);
      chk($sformatf("vec%0d R2/R3/R4/R5/R6 ack", i), {6'h0, v, o}, {6'h0, 1'b1, VEC[i][2]});
      chk($sformatf("vec%0d R2 grant", i), {6'h0, g, g & r}, {6'h0, VEC[i][1], VEC[i][0]});
      do_stop(wr);
      nv_busy = 1'b0;
    end

    // R7: set block 1 with qualifier
    do_start();
    hv_qual = 1'b1;
    send(8'h68, v, o, g, r); a[0] = v & o;
    send(8'h00, v, o, g, r); a[1] = v & o;
    send(8'h00, v, o, g, r); a[2] = v & o;
    chk("R7 flags held before STOP", {4'h0, prot_flags}, 8'h00);
    do_stop(wr);
    hv_qual = 1'b0;
    chk("R7 acks", {5'h0, a}, 8'h07);
    chk("R7 flags", {4'h0, prot_flags}, 8'h02);
    chk("R7 write start", {7'h0, wr}, 8'h01);

    query(8'h69, o); chk("R5 set block queried", {7'h0, o}, 8'h00);
    query(8'h63, o); chk("R5 other block clear", {7'h0, o}, 8'h01);

    // R13: extra byte after a finished query
    do_start();
    send(8'h63, v, o, g, r);
    send(8'h00, v, o, g, r);
    chk("R13 byte after done", {6'h0, v, o}, 8'h02);
    do_stop(wr);

    // R8: set again on block 1
    cmd3(8'h68, 3'b111, a, wr);
    chk("R8 refused", {5'h0, a}, 8'h00);
    chk("R8 no write", {3'h0, wr, prot_flags}, 8'h02);

    // R10: qualifier dropped on the middle byte of set block 3
    cmd3(8'h60, 3'b101, a, wr);
    chk("R10 acks", {5'h0, a}, 8'h03);
    chk("R10 no change", {3'h0, wr, prot_flags}, 8'h02);

    // R12: set block 2 then repeated START
    do_start();
    hv_qual = 1'b1;
    send(8'h6A, v, o, g, r);
    send(8'h00, v, o, g, r);
    send(8'h00, v, o, g, r);
    hv_qual = 1'b0;
    do_start();
    do_stop(wr);
    chk("R12 discarded", {3'h0, wr, prot_flags}, 8'h02);

    // R11: bank select without qualifier
    cmd3(8'h6E, 3'b000, a, wr);
    chk("R11 acks", {5'h0, a}, 8'h07);
    chk("R11 bank 1, no write", {6'h0, bank_act, wr}, 8'h02);
    query(8'h6D, o); chk("R6 bank 1 NoACK", {7'h0, o}, 8'h00);
    cmd3(8'h6C, 3'b000, a, wr);
    chk("R11 bank 0", {6'h0, bank_act, wr}, 8'h00);

    // R9: clear-all, then again on clean flags
    cmd3(8'h66, 3'b111, a, wr);
    chk("R9 acks", {5'h0, a}, 8'h07);
    chk("R9 cleared", {3'h0, wr, prot_flags}, 8'h10);
    cmd3(8'h66, 3'b111, a, wr);
    chk("R9 write on clean", {3'h0, wr, prot_flags}, 8'h10);

    // R10: clear-all with qualifier missing on last byte
    cmd3(8'h62, 3'b111, a, wr);
    cmd3(8'h66, 3'b011, a, wr);
    chk("R10 clear refused", {2'h0, a, wr, prot_flags[0]}, 8'h0D);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule